// File: doc/BRIEF.md
# PCI Master Transaction Ordering Arbiter

This block sits between the requesters that want to use a PCI master port and a simplified master handshake toward that port. Three requesters compete: the CPU-side bus master, whose reads and writes arrive through a single request channel, and two DMA channels. One DMA channel moves data from PCI to memory (DMA reads). The other moves data from memory to PCI (DMA writes). The block grants the port to one requester at a time. It keeps the grant fixed until the port accepts the transaction.

CPU writes are posted into a small queue and acknowledged at once. A CPU read waits for that queue to drain before it goes to PCI. Its returned word stays in a one-entry prefetch buffer, so a repeated read of the same address is answered locally. Any accepted CPU write throws that buffered word away. CPU traffic always beats DMA traffic. When both DMA directions are waiting, they take turns.

The PCI electrical protocol, address decoding and the DMA descriptor engines sit outside this block. A transaction on the master side counts as complete in the cycle where `pm_valid` and `pm_ready` are both high. Read data arrives on `pm_rdata` in that same cycle.

Top module: `pcim_order_arb`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is sampled low, the posted-write queue, the read slot and the prefetch buffer are emptied, and the DMA turn points at reads. After reset, `pm_valid`, `cpu_rsp_valid`, `dma_rd_ready` and `dma_wr_ready` are low and `cpu_req_ready` is high.
- R2: CPU requests reach the master port in exactly the order they were accepted. A CPU write shows on `pm_src` as 0 and a CPU read as 1.
- R3: The posted-write queue holds `WQ_DEPTH` (default 4) writes. While it is full, `cpu_req_ready` is low for a write request.
- R4: A CPU read is issued on the port (`pm_src` = 1) only once every write posted before it has completed. `cpu_rsp_valid` stays low until then. The response data equals the word returned by the port.
- R5: A newly started grant goes to a CPU request (a queued write or a drained read) whenever one is present, ahead of any DMA request.
- R6: When both DMA directions request and no CPU request is present, a new grant goes to the direction that did not complete the most recent DMA transfer. `pm_src` is 2 for a DMA read and 3 for a DMA write. `dma_rd_data` carries `pm_rdata`.
- R7: A DMA direction that requests alone is granted on consecutive transfers without gaps.
- R8: While `pm_valid` is high and `pm_ready` is low, the grant, address and write data hold for the next cycle. At most one of the requester-side completion strobes is high in any cycle.
- R9: A CPU read to the address held in a valid prefetch buffer is answered from the buffer in the cycle after acceptance, with no transaction on the port.
- R10: Acceptance of any CPU write invalidates the prefetch buffer. A later read of the same address goes to the port again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | CPU request accepted this cycle when valid |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | AW | CPU request address |
| cpu_req_wdata | input | DW | CPU write data |
| cpu_rsp_valid | output | 1 | CPU read response present |
| cpu_rsp_ready | input | 1 | CPU takes the response |
| cpu_rsp_data | output | DW | CPU read response data |
| dma_rd_valid | input | 1 | DMA PCI-to-memory transfer request |
| dma_rd_ready | output | 1 | DMA read transfer completes this cycle |
| dma_rd_addr | input | AW | DMA read PCI address |
| dma_rd_data | output | DW | DMA read data, valid with `dma_rd_ready` |
| dma_wr_valid | input | 1 | DMA memory-to-PCI transfer request |
| dma_wr_ready | output | 1 | DMA write transfer completes this cycle |
| dma_wr_addr | input | AW | DMA write PCI address |
| dma_wr_data | input | DW | DMA write data |
| pm_valid | output | 1 | Transaction offered to the master port |
| pm_ready | input | 1 | Master port completes the transaction |
| pm_src | output | 2 | Granted source: 0 CPU write, 1 CPU read, 2 DMA read, 3 DMA write |
| pm_addr | output | AW | Transaction address |
| pm_wdata | output | DW | Transaction write data |
| pm_rdata | input | DW | Read data, valid in the completing cycle |

## Verification
A fault in the queue or read slot shows at the port as a transaction that is out of order, missing or extra. This appears at the very next completion, so the bench compares every completion against an expected stream rather than counting them at the end. A stale prefetch buffer shows only on a later read of the same address, and only if a write came in between. A wrong DMA turn pointer shows only when both directions request at the same time, right after a DMA completion. For that reason the bench starts both DMA streams together, both after a reset and after a run of lone writes.

// File: rtl/pcim_pkg.sv
// Shared types for the PCI master ordering arbiter.
// Assumes the source code values are visible on the pm_src port.
package pcim_pkg;
    typedef enum logic [1:0] {
        SRC_CPU_WR = 2'd0,
        SRC_CPU_RD = 2'd1,
        SRC_DMA_RD = 2'd2,
        SRC_DMA_WR = 2'd3
    } pcim_src_e;
endpackage

// File: rtl/pcim_wq.sv
// Posted-write queue: FIFO of CPU writes waiting for the master port.
// Assumes push is never requested while full (the parent gates it).
module pcim_wq #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          full,
    output logic          head_valid,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count
);
    logic [AW-1:0] addr_mem [DEPTH];
    logic [DW-1:0] data_mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store pushed entries.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_mem[wr_ptr] <= push_addr;
            data_mem[wr_ptr] <= push_data;
        end
    end

    // Advance pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Head view and full flag.
    always_comb begin
        full       = (count == CW'(DEPTH));
        head_valid = (count != '0);
        head_addr  = addr_mem[rd_ptr];
        head_data  = data_mem[rd_ptr];
    end
endmodule

// File: rtl/pcim_rdslot.sv
// CPU read slot with a one-word prefetch buffer.
// A read that hits the buffer tag answers locally; a miss waits for the
// master port and refills the buffer. A flush drops the buffer contents.
// Assumes one outstanding read at a time (the parent blocks new requests).
module pcim_rdslot #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] req_addr,
    input  logic          flush,
    input  logic          pci_done,
    input  logic [DW-1:0] pci_data,
    output logic          busy,
    output logic          need_pci,
    output logic [AW-1:0] rd_addr,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [DW-1:0] rsp_data,
    output logic          pf_valid
);
    typedef enum logic [1:0] {SL_IDLE, SL_WAIT, SL_RESP} slot_e;
    slot_e         st;
    logic [AW-1:0] pf_tag;
    logic [DW-1:0] pf_data;

    // Read slot sequencing and buffer maintenance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SL_IDLE;
            pf_valid <= 1'b0;
            pf_tag   <= '0;
            pf_data  <= '0;
            rd_addr  <= '0;
        end else begin
            case (st)
                SL_IDLE: begin
                    if (flush) pf_valid <= 1'b0;
                    if (req) begin
                        rd_addr <= req_addr;
                        st      <= (pf_valid && pf_tag == req_addr) ? SL_RESP : SL_WAIT;
                    end
                end
                SL_WAIT: if (pci_done) begin
                    pf_valid <= 1'b1;
                    pf_tag   <= rd_addr;
                    pf_data  <= pci_data;
                    st       <= SL_RESP;
                end
                default: if (rsp_ready) st <= SL_IDLE;
            endcase
        end
    end

    // Status and response view.
    always_comb begin
        busy      = (st != SL_IDLE);
        need_pci  = (st == SL_WAIT);
        rsp_valid = (st == SL_RESP);
        rsp_data  = pf_data;
    end
endmodule

// File: rtl/pcim_sel.sv
// Grant selector: CPU write/read over DMA, DMA directions take turns,
// grant held while the master port stalls.
// Assumes requesters keep their request stable until completed.
module pcim_sel
    import pcim_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cpu_wr_req,
    input  logic      cpu_rd_req,
    input  logic      dma_rd_req,
    input  logic      dma_wr_req,
    input  logic      port_ready,
    output logic      grant_valid,
    output pcim_src_e grant_src
);
    logic      hold;
    pcim_src_e held_src;
    logic      turn_wr;

    // Choose the source for this cycle.
    always_comb begin
        grant_valid = 1'b1;
        grant_src   = SRC_CPU_WR;
        if (hold)                        grant_src = held_src;
        else if (cpu_wr_req)             grant_src = SRC_CPU_WR;
        else if (cpu_rd_req)             grant_src = SRC_CPU_RD;
        else if (dma_rd_req && dma_wr_req)
            grant_src = turn_wr ? SRC_DMA_WR : SRC_DMA_RD;
        else if (dma_rd_req)             grant_src = SRC_DMA_RD;
        else if (dma_wr_req)             grant_src = SRC_DMA_WR;
        else                             grant_valid = 1'b0;
    end

    // Remember a stalled grant and the DMA turn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold     <= 1'b0;
            held_src <= SRC_CPU_WR;
            turn_wr  <= 1'b0;
        end else begin
            hold     <= grant_valid && !port_ready;
            held_src <= grant_src;
            if (grant_valid && port_ready) begin
                if (grant_src == SRC_DMA_RD)      turn_wr <= 1'b1;
                else if (grant_src == SRC_DMA_WR) turn_wr <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pcim_order_arb.sv
// PCI master ordering arbiter top: posted-write queue, read slot with
// prefetch buffer, and grant selector toward a valid/ready master port.
// Assumes a port transaction completes when pm_valid && pm_ready.
module pcim_order_arb
    import pcim_pkg::*;
#(
    parameter int WQ_DEPTH = 4,
    parameter int AW       = 32,
    parameter int DW       = 32,
    localparam int CW      = $clog2(WQ_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req_valid,
    output logic          cpu_req_ready,
    input  logic          cpu_req_write,
    input  logic [AW-1:0] cpu_req_addr,
    input  logic [DW-1:0] cpu_req_wdata,
    output logic          cpu_rsp_valid,
    input  logic          cpu_rsp_ready,
    output logic [DW-1:0] cpu_rsp_data,
    input  logic          dma_rd_valid,
    output logic          dma_rd_ready,
    input  logic [AW-1:0] dma_rd_addr,
    output logic [DW-1:0] dma_rd_data,
    input  logic          dma_wr_valid,
    output logic          dma_wr_ready,
    input  logic [AW-1:0] dma_wr_addr,
    input  logic [DW-1:0] dma_wr_data,
    output logic          pm_valid,
    input  logic          pm_ready,
    output logic [1:0]    pm_src,
    output logic [AW-1:0] pm_addr,
    output logic [DW-1:0] pm_wdata,
    input  logic [DW-1:0] pm_rdata
);
    logic          wq_full, wq_head_valid;
    logic [AW-1:0] wq_head_addr;
    logic [DW-1:0] wq_head_data;
    logic [CW-1:0] wq_cnt;
    logic          rd_busy, rd_wait, pf_valid;
    logic [AW-1:0] rd_addr;
    pcim_src_e     src;
    logic          fire, cpu_acc;

    pcim_wq #(.DEPTH(WQ_DEPTH), .AW(AW), .DW(DW)) u_wq (
        .clk(clk), .rst_n(rst_n),
        .push(cpu_acc && cpu_req_write), .push_addr(cpu_req_addr), .push_data(cpu_req_wdata),
        .pop(fire && src == SRC_CPU_WR), .full(wq_full),
        .head_valid(wq_head_valid), .head_addr(wq_head_addr), .head_data(wq_head_data),
        .count(wq_cnt)
    );

    pcim_rdslot #(.AW(AW), .DW(DW)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .req(cpu_acc && !cpu_req_write), .req_addr(cpu_req_addr),
        .flush(cpu_acc && cpu_req_write),
        .pci_done(fire && src == SRC_CPU_RD), .pci_data(pm_rdata),
        .busy(rd_busy), .need_pci(rd_wait), .rd_addr(rd_addr),
        .rsp_valid(cpu_rsp_valid), .rsp_ready(cpu_rsp_ready), .rsp_data(cpu_rsp_data),
        .pf_valid(pf_valid)
    );

    pcim_sel u_sel (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_req(wq_head_valid), .cpu_rd_req(rd_wait && !wq_head_valid),
        .dma_rd_req(dma_rd_valid), .dma_wr_req(dma_wr_valid),
        .port_ready(pm_ready), .grant_valid(pm_valid), .grant_src(src)
    );

    // CPU request acceptance: block everything behind a read in flight.
    always_comb begin
        cpu_req_ready = !rd_busy && !(cpu_req_write && wq_full);
        cpu_acc       = cpu_req_valid && cpu_req_ready;
    end

    // Port payload mux and requester completion strobes.
    always_comb begin
        fire     = pm_valid && pm_ready;
        pm_src   = src;
        pm_addr  = '0;
        pm_wdata = '0;
        case (src)
            SRC_CPU_WR: begin pm_addr = wq_head_addr; pm_wdata = wq_head_data; end
            SRC_CPU_RD: pm_addr = rd_addr;
            SRC_DMA_RD: pm_addr = dma_rd_addr;
            default:    begin pm_addr = dma_wr_addr; pm_wdata = dma_wr_data; end
        endcase
        dma_rd_ready = fire && src == SRC_DMA_RD;
        dma_wr_ready = fire && src == SRC_DMA_WR;
        dma_rd_data  = pm_rdata;
    end
endmodule

// File: rtl/pcim_order_chk.sv
// Property checker for pcim_order_arb, attached by bind.
// Tracks stall and last DMA direction itself to judge fresh grants.
module pcim_order_chk
    import pcim_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req_valid,
    input logic          cpu_req_ready,
    input logic          cpu_req_write,
    input logic          dma_rd_valid,
    input logic          dma_wr_valid,
    input logic          dma_rd_ready,
    input logic          dma_wr_ready,
    input logic          pm_valid,
    input logic          pm_ready,
    input logic [1:0]    pm_src,
    input logic [AW-1:0] pm_addr,
    input logic [DW-1:0] pm_wdata,
    input logic [CW-1:0] wq_cnt,
    input logic          rd_wait,
    input logic          pf_valid
);
    logic prev_stall, last_rd, fresh;

    // Observe stalls and the direction of the last DMA completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_stall <= 1'b0;
            last_rd    <= 1'b0;
        end else begin
            prev_stall <= pm_valid && !pm_ready;
            if (pm_valid && pm_ready && pm_src == SRC_DMA_RD)      last_rd <= 1'b1;
            else if (pm_valid && pm_ready && pm_src == SRC_DMA_WR) last_rd <= 1'b0;
        end
    end

    assign fresh = pm_valid && !prev_stall;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready && cpu_req_write) |-> (wq_cnt < CW'(DEPTH)));

    p_read_drained_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_valid && pm_src == SRC_CPU_RD) |-> (wq_cnt == '0));

    p_cpu_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh && pm_src[1]) |-> (wq_cnt == '0 && !rd_wait));

    p_dma_turn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh && pm_src[1] && dma_rd_valid && dma_wr_valid)
            |-> (pm_src == (last_rd ? SRC_DMA_WR : SRC_DMA_RD)));

    p_grant_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_valid && !pm_ready) |=> (pm_valid && $stable(pm_src) && $stable(pm_addr) && $stable(pm_wdata)));

    p_one_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_rd_ready, dma_wr_ready}));

    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready && cpu_req_write) |=> !pf_valid);
endmodule

bind pcim_order_arb pcim_order_chk #(.DEPTH(WQ_DEPTH), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_write(cpu_req_write),
    .dma_rd_valid(dma_rd_valid), .dma_wr_valid(dma_wr_valid),
    .dma_rd_ready(dma_rd_ready), .dma_wr_ready(dma_wr_ready),
    .pm_valid(pm_valid), .pm_ready(pm_ready), .pm_src(pm_src),
    .pm_addr(pm_addr), .pm_wdata(pm_wdata),
    .wq_cnt(wq_cnt), .rd_wait(rd_wait), .pf_valid(pf_valid)
);

// File: tb/sim_pcim_order_arb.sv
// Scoreboard bench: drivers push expected port transactions, a monitor
// pops and compares each completion on the master port.
module sim_pcim_order_arb;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_req_ready, cpu_rsp_valid;
    logic          cpu_rsp_ready = 1'b1;
    logic [DW-1:0] cpu_rsp_data;
    logic          dma_rd_valid = 1'b0, dma_wr_valid = 1'b0;
    logic [AW-1:0] dma_rd_addr = '0, dma_wr_addr = '0;
    logic [DW-1:0] dma_wr_data = '0, dma_rd_data;
    logic          dma_rd_ready, dma_wr_ready;
    logic          pm_valid;
    logic          pm_ready = 1'b0;
    logic [1:0]    pm_src;
    logic [AW-1:0] pm_addr;
    logic [DW-1:0] pm_wdata, pm_rdata;

    int vectors = 0;
    int errors  = 0;
    int pci_cnt = 0;

    typedef struct {
        logic [1:0]    src;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        string         req;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    assign pm_rdata = pm_addr ^ 32'h5A5A_0000;

    pcim_order_arb u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_data(cpu_rsp_data),
        .dma_rd_valid(dma_rd_valid), .dma_rd_ready(dma_rd_ready),
        .dma_rd_addr(dma_rd_addr), .dma_rd_data(dma_rd_data),
        .dma_wr_valid(dma_wr_valid), .dma_wr_ready(dma_wr_ready),
        .dma_wr_addr(dma_wr_addr), .dma_wr_data(dma_wr_data),
        .pm_valid(pm_valid), .pm_ready(pm_ready), .pm_src(pm_src),
        .pm_addr(pm_addr), .pm_wdata(pm_wdata), .pm_rdata(pm_rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_txn(input logic [1:0] s, input logic [AW-1:0] a,
                              input logic [DW-1:0] d, input string req);
        item_t it;
        it.src = s; it.addr = a; it.data = d; it.req = req;
        exp_q.push_back(it);
    endtask

    // Monitor: compare every port completion against the expected stream.
    always @(negedge clk) begin
        if (rst_n && pm_valid && pm_ready) begin
            pci_cnt++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected port transaction src", 64'(pm_src), 64'hFF);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(pm_src == it.src, it.req, "port source", 64'(pm_src), 64'(it.src));
                check(pm_addr == it.addr, it.req, "port address", 64'(pm_addr), 64'(it.addr));
                if (!it.src[0] && !it.src[1] || it.src == 2'd3)
                    check(pm_wdata == it.data, it.req, "port write data", 64'(pm_wdata), 64'(it.data));
                if (it.src == 2'd2)
                    check(dma_rd_data == (pm_addr ^ 32'h5A5A_0000), "R6", "dma read data",
                          64'(dma_rd_data), 64'(pm_addr ^ 32'h5A5A_0000));
            end
        end
    end

    task automatic cpu_send(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = w; cpu_req_addr = a; cpu_req_wdata = d;
        #1;
        while (!cpu_req_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
    endtask

    task automatic cpu_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        cpu_send(1'b0, a, '0);
        while (!cpu_rsp_valid) @(negedge clk);
        d = cpu_rsp_data;
    endtask

    task automatic dma_burst(input bit wr, input int n, input logic [AW-1:0] base);
        for (int i = 0; i < n; i++) begin
            if (wr) begin
                dma_wr_valid = 1'b1; dma_wr_addr = base + AW'(i*4); dma_wr_data = base + DW'(i) + 32'h100;
                #1;
                while (!dma_wr_ready) begin @(negedge clk); #1; end
            end else begin
                dma_rd_valid = 1'b1; dma_rd_addr = base + AW'(i*4);
                #1;
                while (!dma_rd_ready) begin @(negedge clk); #1; end
            end
            @(posedge clk);
            @(negedge clk);
        end
        if (wr) dma_wr_valid = 1'b0; else dma_rd_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : stim
        logic [DW-1:0] d;
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after reset
        check(pm_valid == 1'b0, "R1", "pm_valid after reset", 64'(pm_valid), 64'd0);
        check(cpu_req_ready == 1'b1, "R1", "cpu_req_ready after reset", 64'(cpu_req_ready), 64'd1);
        check(cpu_rsp_valid == 1'b0, "R1", "cpu_rsp_valid after reset", 64'(cpu_rsp_valid), 64'd0);
        check(!dma_rd_ready && !dma_wr_ready, "R1", "dma readies after reset",
              64'({dma_rd_ready, dma_wr_ready}), 64'd0);

        // R2/R3/R4: four posted writes with the port stalled, then a read.
        pm_ready = 1'b0;
        for (int i = 0; i < 4; i++) begin
            expect_txn(2'd0, 32'h1000 + 32'(i*4), 32'hA000 + 32'(i), "R2");
            cpu_send(1'b1, 32'h1000 + 32'(i*4), 32'hA000 + 32'(i));
        end
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = 32'h1FF0;
        #1;
        check(cpu_req_ready == 1'b0, "R3", "ready with full queue", 64'(cpu_req_ready), 64'd0);
        cpu_req_valid = 1'b0;
        // R8: grant holds while stalled
        check(pm_valid && pm_src == 2'd0 && pm_addr == 32'h1000, "R8", "held grant address",
              64'(pm_addr), 64'h1000);
        expect_txn(2'd1, 32'h2000, '0, "R4");
        fork
            begin
                cpu_read(32'h2000, d);
                check(d == (32'h2000 ^ 32'h5A5A_0000), "R4", "read data", 64'(d), 64'(32'h2000 ^ 32'h5A5A_0000));
            end
            begin
                repeat (4) @(negedge clk);
                check(cpu_rsp_valid == 1'b0, "R4", "response before drain", 64'(cpu_rsp_valid), 64'd0);
                check(pm_src != 2'd1, "R4", "read issued before drain", 64'(pm_src), 64'd0);
                pm_ready = 1'b1;
            end
        join
        drain();

        // R5/R6: CPU write ahead of two DMA streams, then alternation.
        pm_ready = 1'b0;
        expect_txn(2'd0, 32'h3000, 32'hBEEF, "R5");
        cpu_send(1'b1, 32'h3000, 32'hBEEF);
        expect_txn(2'd2, 32'h4000, '0, "R6");
        expect_txn(2'd3, 32'h5000, 32'h5100, "R6");
        expect_txn(2'd2, 32'h4004, '0, "R6");
        expect_txn(2'd3, 32'h5004, 32'h5101, "R6");
        fork
            dma_burst(1'b0, 2, 32'h4000);
            dma_burst(1'b1, 2, 32'h5000);
            begin repeat (3) @(negedge clk); pm_ready = 1'b1; end
        join
        drain();

        // R7: lone DMA writes back-to-back, then turn goes to reads.
        for (int i = 0; i < 3; i++)
            expect_txn(2'd3, 32'h6000 + 32'(i*4), 32'h6100 + 32'(i), "R7");
        @(negedge clk);
        c0 = pci_cnt;
        dma_burst(1'b1, 3, 32'h6000);
        check(pci_cnt - c0 == 3, "R7", "lone DMA writes without gaps (count)", 64'(pci_cnt - c0), 64'd3);
        drain();
        expect_txn(2'd2, 32'h7000, '0, "R6");
        expect_txn(2'd3, 32'h8000, 32'h8100, "R6");
        @(negedge clk);
        fork
            dma_burst(1'b0, 1, 32'h7000);
            dma_burst(1'b1, 1, 32'h8000);
        join
        drain();

        // R9/R10: prefetch hit, flush by write, refetch.
        expect_txn(2'd1, 32'h9000, '0, "R9");
        cpu_read(32'h9000, d);
        drain();
        c0 = pci_cnt;
        cpu_read(32'h9000, d);
        repeat (2) @(negedge clk);
        check(pci_cnt == c0, "R9", "port transactions on buffer hit", 64'(pci_cnt - c0), 64'd0);
        check(d == (32'h9000 ^ 32'h5A5A_0000), "R9", "hit data", 64'(d), 64'(32'h9000 ^ 32'h5A5A_0000));
        expect_txn(2'd0, 32'hA000, 32'h1234, "R10");
        cpu_send(1'b1, 32'hA000, 32'h1234);
        expect_txn(2'd1, 32'h9000, '0, "R10");
        cpu_read(32'h9000, d);
        drain();
        check(pci_cnt == c0 + 2, "R10", "refetch after write", 64'(pci_cnt - c0), 64'd2);

        // R1: mid-run reset empties the posted-write queue.
        pm_ready = 1'b0;
        cpu_send(1'b1, 32'hB000, 32'h1);
        cpu_send(1'b1, 32'hB004, 32'h2);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pm_valid == 1'b0, "R1", "pm_valid after mid-run reset", 64'(pm_valid), 64'd0);
        pm_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(pm_valid == 1'b0, "R1", "queue emptied by reset", 64'(pm_valid), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule